// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Unit with Condition Flags and Compare

This block is a purely combinational arithmetic logic unit. It operates on two small operands. A 3-bit operation code picks one of six functions: addition, subtraction, bitwise AND, bitwise OR, bitwise XOR, and inversion of the first operand. Every functional unit works on the operands at the same time, and an output multiplexer driven by the operation code passes the selected result to the output. The block has no clock, no reset and no stored state. A surrounding datapath registers whatever it needs.

The four condition flags are computed beside the result: zero, carry, negative and signed overflow. The arithmetic unit is one ripple-carry adder. For subtraction it inverts the second operand and forces a carry-in of one, so the carry flag after a subtraction reads as "no borrow". Two compare outputs come straight from the flags. Running a subtraction therefore also gives an equality test and a signed less-than test, with no extra comparator.

Top module: `nib_alu`

## Requirements
- R1: With op code 000 (add), the result is (A + B) mod 2^WIDTH, and the carry flag is 1 exactly when the unsigned sum exceeds 2^WIDTH − 1.
- R2: With op code 001 (subtract), the result is (A − B) mod 2^WIDTH, formed as A + ~B + 1. The carry flag is 1 exactly when A ≥ B as unsigned numbers, so borrow (the inverted carry) means A < B.
- R3: For add and subtract, the overflow flag is 1 exactly when the true two's-complement result falls outside −2^(WIDTH−1) .. 2^(WIDTH−1)−1 (for example 7+1 gives 1000 with overflow 1 and carry 0, and 0 − (−8) gives overflow 1).
- R4: For every defined op code (000 to 101), the zero flag is 1 exactly when every result bit is 0. It depends only on the result, not on the operands.
- R5: For every defined op code, the negative flag equals the most significant result bit.
- R6: Op codes 010, 011 and 100 give the bitwise AND, OR and XOR of A and B.
- R7: Op code 101 gives the bitwise inverse of A and ignores B. For all four logic op codes (010 to 101), the carry and overflow flags are 0.
- R8: The equal output always equals the zero flag, and the signed less-than output always equals negative XOR overflow. With op code 001 they therefore report A = B and signed A < B.
- R9: The unused op codes 110 and 111 give a zero result, with the zero, carry, negative and overflow flags, equal and less-than all 0.
- R10: The outputs depend only on the present inputs. The same inputs give the same outputs whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| result | output | WIDTH | Selected result |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry out of the top adder stage (arithmetic ops only) |
| flag_n | output | 1 | Negative flag (top result bit) |
| flag_v | output | 1 | Signed overflow flag (arithmetic ops only) |
| cmp_eq | output | 1 | Equal compare, taken from the zero flag |
| cmp_lt | output | 1 | Signed less-than compare, negative XOR overflow |

## Verification
No register lies between any input and any output. The result, all four flags and both compare outputs are therefore due in the same cycle the operands and op code are applied, after the combinational logic settles. The bench drives each vector on the falling clock edge and samples every output one nanosecond later, still inside that half period, so no sample depends on a clock edge. It applies every operand pair under all eight op codes, then random vectors and a few directed corner vectors. The history check repeats an earlier vector after unrelated ones and expects identical outputs.

// File: rtl/nib_alu_pkg.sv
`timescale 1ns/1ps
package nib_alu_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
  localparam logic [OP_W-1:0] OP_SUB  = 3'd1;
  localparam logic [OP_W-1:0] OP_AND  = 3'd2;
  localparam logic [OP_W-1:0] OP_OR   = 3'd3;
  localparam logic [OP_W-1:0] OP_XOR  = 3'd4;
  localparam logic [OP_W-1:0] OP_NOTA = 3'd5;

  // arithmetic op codes share the adder
  function automatic logic op_is_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  // logic op codes go through the bitwise unit
  function automatic logic op_is_logic(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOTA);
  endfunction

  // one full-adder carry
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (ci & (x ^ y));
  endfunction
endpackage

// File: rtl/nib_alu_addsub.sv
`timescale 1ns/1ps
module nib_alu_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  import nib_alu_pkg::*;

  logic [WIDTH:0]   carry_chain;
  logic [WIDTH-1:0] b_eff;

  assign b_eff          = b ^ {WIDTH{sub}};
  assign carry_chain[0] = sub;

  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_stage
    assign sum[gi]           = a[gi] ^ b_eff[gi] ^ carry_chain[gi];
    assign carry_chain[gi+1] = fa_carry(a[gi], b_eff[gi], carry_chain[gi]);
  end

  assign cout = carry_chain[WIDTH];
  // signed overflow: carry into the top stage differs from carry out
  assign ovf  = carry_chain[WIDTH] ^ carry_chain[WIDTH-1];

  // wide signed view of the true result, for the checks only
  logic signed [WIDTH:0] true_wide;
  always_comb begin
    if (sub) true_wide = $signed({a[WIDTH-1], a}) - $signed({b[WIDTH-1], b});
    else     true_wide = $signed({a[WIDTH-1], a}) + $signed({b[WIDTH-1], b});
  end

  always_comb begin
    if (!$isunknown({a, b, sub})) begin
      assert_no_borrow_R2: assert (!sub || (cout == (a >= b)))
        else $error("subtract carry disagrees with unsigned compare");
      assert_signed_range_R3: assert (ovf == (true_wide[WIDTH] != true_wide[WIDTH-1]))
        else $error("overflow flag disagrees with signed range");
      assert_low_bits_R1: assert (sum == true_wide[WIDTH-1:0])
        else $error("adder sum disagrees with wide result");
    end
  end
endmodule

// File: rtl/nib_alu_logic.sv
`timescale 1ns/1ps
module nib_alu_logic #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]            a,
  input  logic [WIDTH-1:0]            b,
  input  logic [nib_alu_pkg::OP_W-1:0] op,
  output logic [WIDTH-1:0]            res
);
  import nib_alu_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOTA: res = ~a;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a, op})) begin
      assert_inverse_R7: assert (op != OP_NOTA || ((res ^ a) == {WIDTH{1'b1}}))
        else $error("inversion result not complementary to A");
    end
  end
endmodule

// File: rtl/nib_alu_flags.sv
`timescale 1ns/1ps
module nib_alu_flags #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] res,
  input  logic             raw_c,
  input  logic             raw_v,
  input  logic             arith,
  input  logic             valid,
  output logic             z,
  output logic             c,
  output logic             n,
  output logic             v
);
  // zero is a NOR across the result bits only
  assign z = valid & ~(|res);
  assign n = valid & res[WIDTH-1];
  assign c = arith & raw_c;
  assign v = arith & raw_v;

  always_comb begin
    if (!$isunknown({res, raw_c, raw_v, arith, valid})) begin
      assert_z_only_zero_R4: assert (!z || (res == '0))
        else $error("zero flag set with nonzero result");
      assert_flags_quiet_R9: assert (valid || !(z | c | n | v))
        else $error("flag raised on unused code");
    end
  end
endmodule

// File: rtl/nib_alu.sv
`timescale 1ns/1ps
module nib_alu #(
  parameter int WIDTH = 4
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_n,
  output logic             flag_v,
  output logic             cmp_eq,
  output logic             cmp_lt
);
  import nib_alu_pkg::*;

  // named internal events
  logic [WIDTH-1:0] arith_res;
  logic [WIDTH-1:0] logic_res;
  logic             arith_cout;
  logic             arith_ovf;
  logic             sel_arith;
  logic             sel_logic;
  logic             sel_valid;

  assign sel_arith = op_is_arith(op_sel);
  assign sel_logic = op_is_logic(op_sel);
  assign sel_valid = sel_arith | sel_logic;

  nib_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a    (opnd_a),
    .b    (opnd_b),
    .sub  (op_sel == OP_SUB),
    .sum  (arith_res),
    .cout (arith_cout),
    .ovf  (arith_ovf)
  );

  nib_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .op  (op_sel),
    .res (logic_res)
  );

  // output steering: units already finished, mux only selects
  always_comb begin
    if (sel_arith)      result = arith_res;
    else if (sel_logic) result = logic_res;
    else                result = '0;
  end

  nib_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res   (result),
    .raw_c (arith_cout),
    .raw_v (arith_ovf),
    .arith (sel_arith),
    .valid (sel_valid),
    .z     (flag_z),
    .c     (flag_c),
    .n     (flag_n),
    .v     (flag_v)
  );

  assign cmp_eq = flag_z;
  assign cmp_lt = flag_n ^ flag_v;

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b})) begin
      assert_cmp_equal_R8: assert (op_sel != OP_SUB || (cmp_eq == (opnd_a == opnd_b)))
        else $error("equal output wrong on subtract");
      assert_cmp_less_R8: assert (op_sel != OP_SUB ||
                                  (cmp_lt == ($signed(opnd_a) < $signed(opnd_b))))
        else $error("less-than output wrong on subtract");
      assert_logic_no_cv_R7: assert (!sel_logic || !(flag_c | flag_v))
        else $error("carry or overflow set on a logic op");
      assert_unused_zero_R9: assert (sel_valid || (result == '0 && !cmp_eq && !cmp_lt))
        else $error("unused code produced output");
    end
  end
endmodule

// File: tb/nib_alu_tb.sv
`timescale 1ns/1ps
module nib_alu_tb;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk; // 250 MHz

  logic [2:0]   op_sel = 3'd0;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [W-1:0] result;
  logic flag_z, flag_c, flag_n, flag_v, cmp_eq, cmp_lt;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  nib_alu #(.WIDTH(W)) u_dut (
    .op_sel (op_sel), .opnd_a (opnd_a), .opnd_b (opnd_b),
    .result (result), .flag_z (flag_z), .flag_c (flag_c),
    .flag_n (flag_n), .flag_v (flag_v), .cmp_eq (cmp_eq), .cmp_lt (cmp_lt)
  );

  function automatic int sval(input int u);
    return (u > (MASK >> 1)) ? u - (MASK + 1) : u;
  endfunction

  // expected packed as {res, z, c, n, v, eq, lt}
  function automatic logic [W+5:0] model(input int op, input int a, input int b);
    int r; logic z, c, n, v, ok; int s;
    r = 0; c = 0; v = 0; ok = 1;
    case (op)
      0: begin r = (a + b) & MASK; c = (a + b) > MASK; s = sval(a) + sval(b);
               v = (s > (MASK >> 1)) || (s < -((MASK >> 1) + 1)); end
      1: begin r = (a - b) & MASK; c = (a >= b); s = sval(a) - sval(b);
               v = (s > (MASK >> 1)) || (s < -((MASK >> 1) + 1)); end
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = (~a) & MASK;
      default: ok = 0;
    endcase
    z = ok && (r == 0);
    n = ok && ((r >> (W - 1)) & 1);
    return {r[W-1:0], z, c, n, v, z, n ^ v};
  endfunction

  function automatic string res_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R6";
      5: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what,
                     input int op, input int a, input int b);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s op=%0d a=%0d b=%0d actual=%0d expected=%0d",
               req, what, op, a, b, act, exp);
    end
  endtask

  task automatic apply(input int op, input int a, input int b);
    logic [W+5:0] e;
    string ct, vt;
    @(negedge clk);
    op_sel = op[2:0]; opnd_a = a[W-1:0]; opnd_b = b[W-1:0];
    #1; // combinational: due in this same cycle
    e  = model(op, a, b);
    ct = (op == 0) ? "R1" : (op == 1) ? "R2" : (op <= 5) ? "R7" : "R9";
    vt = (op <= 1) ? "R3" : (op <= 5) ? "R7" : "R9";
    chk(res_tag(op), int'(result), int'(e[W+5:6]), "result", op, a, b);
    chk((op <= 5) ? "R4" : "R9", int'(flag_z), int'(e[5]), "zero", op, a, b);
    chk(ct, int'(flag_c), int'(e[4]), "carry", op, a, b);
    chk((op <= 5) ? "R5" : "R9", int'(flag_n), int'(e[3]), "negative", op, a, b);
    chk(vt, int'(flag_v), int'(e[2]), "overflow", op, a, b);
    chk("R8", int'(cmp_eq), int'(e[1]), "equal", op, a, b);
    chk("R8", int'(cmp_lt), int'(e[0]), "less", op, a, b);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] keep_r;
    logic [5:0]   keep_f;
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // initial state: add of zero operands
    #1;
    chk("R4", int'(flag_z), 1, "initial zero", 0, 0, 0);
    chk("R1", int'(result), 0, "initial result", 0, 0, 0);

    // directed corners
    apply(0, 7, 1);    // R3: 7+1 overflows, no carry
    chk("R3", int'(flag_c), 0, "7+1 carry", 0, 7, 1);
    apply(1, 0, 8);    // R3: 0-(-8) overflows
    chk("R3", int'(flag_v), 1, "0-(-8) overflow", 1, 0, 8);
    apply(1, 3, 5);    // R2: borrow when A<B
    chk("R2", int'(!flag_c), 1, "borrow", 1, 3, 5);
    apply(1, 9, 9);    // R8: equal, zero with negative operands
    chk("R8", int'(cmp_eq), 1, "equal", 1, 9, 9);
    apply(5, 15, 6);   // R7: NOT of all ones is zero
    apply(6, 15, 15);  // R9
    apply(7, 8, 8);    // R9

    // R10: same vector after unrelated ones gives the same outputs
    apply(0, 12, 11);
    keep_r = result;
    keep_f = {flag_z, flag_c, flag_n, flag_v, cmp_eq, cmp_lt};
    apply(4, 3, 6);
    apply(1, 15, 0);
    apply(0, 12, 11);
    chk("R10", int'(result), int'(keep_r), "repeat result", 0, 12, 11);
    chk("R10", int'({flag_z, flag_c, flag_n, flag_v, cmp_eq, cmp_lt}), int'(keep_f),
        "repeat flags", 0, 12, 11);

    // exhaustive sweep over every op code and operand pair
    for (int op = 0; op < 8; op++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          apply(op, a, b);

    // constrained random: mostly defined codes
    for (int i = 0; i < 300; i++)
      apply(($urandom % 10 < 9) ? int'($urandom % 6) : int'(6 + $urandom % 2),
            int'($urandom & MASK), int'($urandom & MASK));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule